// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator with Interrupt Routing

This block holds two time-of-day alarm settings and compares them with a running BCD clock. Each setting is four bytes: seconds, minutes, hours and day of week. The top bit of every byte is a "don't care" mask that removes that field from the comparison. Depending on which fields are masked, an alarm fires anywhere from once per second to once per week. The clock counter sits outside the block. It presents the current time on four byte inputs and pulses `tick` for one cycle after every update. The block evaluates the alarms only on that pulse.

A match sets a sticky request flag for that alarm. Two active-low interrupt lines carry the flags to a processor. A routing bit in the control byte selects the wiring. Either each alarm drives its own line, or both alarms share interrupt 0. Each alarm also has its own enable bit. A flag is cleared as a side effect of host accesses. Any read or write whose address lands on one of that alarm's four registers clears it.

Host accesses arrive through a single-cycle strobe (`acc_valid`) with an address and write data. There is no back-pressure: an access is accepted in every cycle the strobe is high. Read data is combinational from the address, and the host samples it in the same cycle. Address bit 7 set means write, clear means read. The low seven bits give the register offset.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset, all alarm bytes are 0, the control byte is 0, both flags are 0 and both `int0_n` and `int1_n` are high.
- R2: The register offsets are as follows:
  - Alarm 0 seconds, minutes, hours and day are at 07h, 08h, 09h and 0Ah.
  - Alarm 1 uses the same order at 0Bh to 0Eh.
  - Control is at 0Fh.
  - Status is at 10h and is read-only.
  - Every other offset reads 0.
  - A write uses address 80h plus the offset.
  - Alarm bytes read back all eight bits as written.
- R3: A field takes part in the compare only when its bit 7 is 0. It then matches when bits 6:0 equal the current value's bits 6:0. For the hour field this includes the 12/24 bit (6) and the AM/PM bit (5). An alarm hits when every unmasked field matches.
- R4: A flag sets only on a cycle with `tick` high and its alarm hitting. Without `tick`, no flag changes because of a match. Once set, a flag stays set until it is cleared.
- R5: A flag sets regardless of its enable bit. An interrupt line goes low only while a flag that routes to it is set and that flag's enable is 1.
- R6: With the routing bit at 1, `int0_n` follows flag 0 AND enable 0, and `int1_n` follows flag 1 AND enable 1.
- R7: With the routing bit at 0, `int0_n` is low when either alarm's flag and enable are both set, and `int1_n` stays high.
- R8: A read or write to any of an alarm's four offsets clears that alarm's flag one cycle later and leaves the other flag unchanged. If a tick hit and a clearing access land in the same cycle, the flag ends set.
- R9: The status byte returns flag 0 in bit 0 and flag 1 in bit 1, with bits 7:2 reading 0.
- R10: While the write-protect bit is 1, writes to the alarm bytes and to control bits 7, 2, 1 and 0 are ignored. The write-protect bit itself stays writable, and the flag-clearing side effect of an access still applies.
- R11: The control byte holds oscillator-stop in bit 7, write-protect in bit 6, routing in bit 2, alarm 1 enable in bit 1 and alarm 0 enable in bit 0. Bits 5:3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse after each clock update |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours with 12/24 and AM/PM bits |
| cur_day | input | 8 | Current day of week |
| acc_valid | input | 1 | Host access strobe |
| acc_addr | input | 8 | Bit 7 write flag, bits 6:0 offset |
| acc_wdata | input | 8 | Host write data |
| rd_data | output | 8 | Read data for the offset on acc_addr |
| int0_n | output | 1 | Interrupt 0, active low |
| int1_n | output | 1 | Interrupt 1, active low |

## Verification
The hardest state to reach is a full cross of the mask patterns with partial matches. Every one of the sixteen mask combinations must meet every combination of matching and mismatching fields. One mismatch must differ only in the AM/PM bit of the hour.

The bench sweeps all 256 such pairs for alarm 0. It rewrites the alarm bytes, moves the current time, pulses `tick`, and then reads the status and the interrupt line. Directed sequences then cover these cases:
- both flags set together, with one cleared and the other kept;
- a tick colliding with a clearing access in the same cycle;
- writes attempted under write protect.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int BYTE_W     = 8;
  localparam int FIELDS     = 4;
  localparam int NUM_ALARMS = 2;
  localparam int ALARM_BASE = 7;
  localparam int CTRL_OFS   = ALARM_BASE + NUM_ALARMS * FIELDS;
  localparam int STAT_OFS   = CTRL_OFS + 1;

  localparam int CB_OSC   = 7;
  localparam int CB_WP    = 6;
  localparam int CB_ROUTE = 2;
  localparam int CB_EN1   = 1;
  localparam int CB_EN0   = 0;
  localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'hC7;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [FIELDS-1:0][BYTE_W-1:0] alarm_set_t;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_irq_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int NF = FIELDS
) (
  input  logic [NF-1:0][W-1:0] setting,
  input  logic [NF-1:0][W-1:0] now,
  output logic                 hit
);
  logic [NF-1:0] field_ok;

  for (genvar f = 0; f < NF; f++) begin : g_field
    assign field_ok[f] = setting[f][W-1] | (setting[f][W-2:0] == now[f][W-2:0]);
  end

  assign hit = &field_ok;
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (tick && hit) flag_q <= 1'b1;
    else if (clr)        flag_q <= 1'b0;
  end

  assign flag = flag_q;

  a_r4_set_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick && hit));
  a_r8_clear_by_access: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr));
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit && clr) |=> flag_q);
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_irq_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int NF = FIELDS,
  parameter int NA = NUM_ALARMS,
  parameter int AW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          acc_valid,
  input  logic [AW-1:0]                 acc_addr,
  input  logic [W-1:0]                  acc_wdata,
  input  logic [NA-1:0]                 flags,
  output logic [NA-1:0][NF-1:0][W-1:0]  alarms,
  output logic [W-1:0]                  ctrl,
  output logic [NA-1:0]                 clr,
  output logic [W-1:0]                  rd_data
);
  localparam int OW = AW - 1;

  logic [OW-1:0]               ofs;
  logic                        is_wr;
  logic                        wr_en;
  logic [NA-1:0][NF-1:0][W-1:0] alarm_q;
  logic [W-1:0]                ctrl_q;

  assign ofs   = acc_addr[OW-1:0];
  assign is_wr = acc_addr[AW-1];
  assign wr_en = acc_valid && is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      ctrl_q  <= '0;
    end else if (wr_en) begin
      for (int a = 0; a < NA; a++)
        for (int f = 0; f < NF; f++)
          if (ofs == OW'(ALARM_BASE + a * NF + f) && !ctrl_q[CB_WP])
            alarm_q[a][f] <= acc_wdata;
      if (ofs == OW'(CTRL_OFS)) begin
        if (ctrl_q[CB_WP]) ctrl_q[CB_WP] <= acc_wdata[CB_WP];
        else               ctrl_q <= acc_wdata & CTRL_KEEP;
      end
    end
  end

  for (genvar a = 0; a < NA; a++) begin : g_clr
    assign clr[a] = acc_valid &&
                    (ofs >= OW'(ALARM_BASE + a * NF)) &&
                    (ofs <  OW'(ALARM_BASE + (a + 1) * NF));
  end

  always_comb begin
    rd_data = '0;
    if (!is_wr) begin
      for (int a = 0; a < NA; a++)
        for (int f = 0; f < NF; f++)
          if (ofs == OW'(ALARM_BASE + a * NF + f)) rd_data = alarm_q[a][f];
      if (ofs == OW'(CTRL_OFS)) rd_data = ctrl_q;
      if (ofs == OW'(STAT_OFS)) rd_data = W'(flags);
    end
  end

  assign alarms = alarm_q;
  assign ctrl   = ctrl_q;

  a_r10_wp_freezes_alarms: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctrl_q[CB_WP]) |=> $stable(alarm_q));
  a_r10_wp_freezes_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctrl_q[CB_WP]) |=> ((ctrl_q & CTRL_KEEP & ~(W'(1) << CB_WP)) ==
                                  ($past(ctrl_q) & CTRL_KEEP & ~(W'(1) << CB_WP))));
  a_r11_ctrl_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_KEEP) == '0);
  a_r9_status_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_wr && ofs == OW'(STAT_OFS)) |-> (rd_data >> NA) == '0);
endmodule

// File: rtl/irq_route.sv
module irq_route
  import alarm_irq_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ctrl,
  input  logic [1:0]   flags,
  output logic         int0_n,
  output logic         int1_n
);
  logic req0, req1, split;

  assign req0  = flags[0] && ctrl[CB_EN0];
  assign req1  = flags[1] && ctrl[CB_EN1];
  assign split = ctrl[CB_ROUTE];

  assign int0_n = !(req0 || (!split && req1));
  assign int1_n = !(split && req1);

  a_r7_int1_idle_when_merged: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CB_ROUTE] |-> int1_n);
  a_r5_disabled_lines_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[CB_EN0] && !ctrl[CB_EN1]) |-> (int0_n && int1_n));
  a_r5_no_flag_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 2'b00) |-> (int0_n && int1_n));
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [W-1:0]  cur_sec,
  input  logic [W-1:0]  cur_min,
  input  logic [W-1:0]  cur_hour,
  input  logic [W-1:0]  cur_day,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [W-1:0]  acc_wdata,
  output logic [W-1:0]  rd_data,
  output logic          int0_n,
  output logic          int1_n
);
  logic [FIELDS-1:0][W-1:0]             now;
  logic [NUM_ALARMS-1:0][FIELDS-1:0][W-1:0] alarms;
  logic [W-1:0]                         ctrl;
  logic [NUM_ALARMS-1:0]                clr, hit, flags;

  assign now = {cur_day, cur_hour, cur_min, cur_sec};

  alarm_regs #(.W(W), .NF(FIELDS), .NA(NUM_ALARMS), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .flags(flags), .alarms(alarms), .ctrl(ctrl),
    .clr(clr), .rd_data(rd_data));

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
    alarm_match #(.W(W), .NF(FIELDS)) match_i (
      .setting(alarms[a]), .now(now), .hit(hit[a]));
    alarm_flag flag_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hit(hit[a]),
      .clr(clr[a]), .flag(flags[a]));
  end

  irq_route #(.W(W)) route_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .flags(flags),
    .int0_n(int0_n), .int1_n(int1_n));

  a_r4_quiet_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !acc_valid) |=> $stable(flags));
endmodule

// File: tb/alarm_irq_ctrl_tb.sv
module alarm_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00, cur_day = 8'h00;
  logic       acc_valid = 1'b0;
  logic [7:0] acc_addr = 8'h00, acc_wdata = 8'h00;
  logic [7:0] rd_data;
  logic       int0_n, int1_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alarm_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_day(cur_day), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .int0_n(int0_n), .int1_n(int1_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] ofs, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = {1'b1, ofs}; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic rd(input logic [6:0] ofs, output logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = {1'b0, ofs};
    #1 d = rd_data;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic check_reg(input logic [6:0] ofs, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(ofs, v);
    check(v == exp, req, v, exp);
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] aval [4];
    logic [7:0] miss [4];
    aval[0] = 8'h25; aval[1] = 8'h41; aval[2] = 8'h52; aval[3] = 8'h03;
    miss[0] = 8'h26; miss[1] = 8'h40; miss[2] = 8'h72; miss[3] = 8'h04;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    check(int0_n && int1_n, "R1 int lines idle", {int0_n, int1_n}, 2'b11);
    check_reg(7'h10, 8'h00, "R1 status");
    check_reg(7'h0F, 8'h00, "R1 control");
    check_reg(7'h07, 8'h00, "R1 alarm0 sec");
    check_reg(7'h0E, 8'h00, "R1 alarm1 day");

    // R2 map and readback, R11 control layout
    wr(7'h0E, 8'hA5);
    check_reg(7'h0E, 8'hA5, "R2 alarm1 day readback");
    check_reg(7'h12, 8'h00, "R2 unused offset");
    wr(7'h0F, 8'hBF);
    check_reg(7'h0F, 8'h87, "R11 control reserved bits");
    wr(7'h10, 8'hFF);
    check_reg(7'h10, 8'h00, "R2 status read-only");
    wr(7'h0E, 8'h00);

    // R3/R4/R9 sweep over masks and partial matches (alarm 0, merged routing, en0)
    wr(7'h0F, 8'h01);
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        bit exp_hit;
        exp_hit = 1'b1;
        for (int f = 0; f < 4; f++) begin
          wr(7'(7 + f), aval[f] | (m[f] ? 8'h80 : 8'h00));
          if (!m[f] && p[f]) exp_hit = 1'b0;
        end
        cur_sec  = p[0] ? miss[0] : aval[0];
        cur_min  = p[1] ? miss[1] : aval[1];
        cur_hour = p[2] ? miss[2] : aval[2];
        cur_day  = p[3] ? miss[3] : aval[3];
        pulse_tick();
        #1;
        check(int0_n == !exp_hit, "R3 int0 after tick", int0_n, !exp_hit);
        rd(7'h10, v);
        check(v == {7'b0, exp_hit}, "R3 R9 status after tick", v, {7'b0, exp_hit});
      end
    end
    rd(7'h07, v);

    // R4 no tick, no flag
    for (int f = 0; f < 4; f++) wr(7'(7 + f), 8'h80);
    repeat (5) @(negedge clk);
    check_reg(7'h10, 8'h00, "R4 no flag without tick");
    pulse_tick();
    check_reg(7'h10, 8'h01, "R4 flag on tick");
    rd(7'h08, v);

    // R5 flag with enable off
    wr(7'h0F, 8'h00);
    pulse_tick();
    #1;
    check(int0_n == 1'b1, "R5 disabled int0 idle", int0_n, 1);
    check_reg(7'h10, 8'h01, "R5 flag sets while disabled");
    wr(7'h0F, 8'h01);
    #1;
    check(int0_n == 1'b0, "R5 enable asserts int0", int0_n, 0);

    // R8 selective clear, both flags set
    for (int f = 0; f < 4; f++) wr(7'(11 + f), 8'h80);
    pulse_tick();
    check_reg(7'h10, 8'h03, "R8 both flags set");
    rd(7'h0B, v);
    check_reg(7'h10, 8'h01, "R8 alarm1 read clears only flag1");
    wr(7'h89, 8'h80);
    check_reg(7'h10, 8'h00, "R8 alarm0 write clears flag0");
    // same-cycle tick and clearing access
    @(negedge clk);
    tick = 1'b1; acc_valid = 1'b1; acc_addr = 8'h07;
    @(negedge clk);
    tick = 1'b0; acc_valid = 1'b0;
    check_reg(7'h10, 8'h03, "R8 set wins over clear");
    rd(7'h0A, v); rd(7'h0D, v);

    // R6 split routing: only alarm1 hits
    wr(7'h07, 8'h11);
    wr(7'h0F, 8'h07);
    pulse_tick();
    #1;
    check({int0_n, int1_n} == 2'b10, "R6 split alarm1 on int1", {int0_n, int1_n}, 2'b10);
    // R7 merged routing
    wr(7'h0F, 8'h03);
    #1;
    check({int0_n, int1_n} == 2'b01, "R7 merged alarm1 on int0", {int0_n, int1_n}, 2'b01);
    wr(7'h0F, 8'h01);
    #1;
    check(int0_n == 1'b1, "R7 en1 off gates alarm1", int0_n, 1);
    rd(7'h0C, v);

    // R10 write protect
    wr(7'h0F, 8'h47);
    wr(7'h07, 8'h22);
    check_reg(7'h07, 8'h11, "R10 alarm write blocked");
    wr(7'h0F, 8'h80);
    check_reg(7'h0F, 8'h07, "R10 only wp bit writable");
    wr(7'h07, 8'h33);
    check_reg(7'h07, 8'h33, "R10 write after unprotect");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule